// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block forms the word address for every beat of a short burst on a synchronous burst memory. Either of two active-low start strobes captures a full address from the bus: one from the processor side and one from the memory controller side. After the capture, the low address bits come from an internal beat counter. The upper bits stay as they were captured until the next start.

The counter moves forward only in cycles where the active-low advance input is sampled low. A static ordering input chooses how the counter value is combined with the captured low bits. In interleaved order the two are XORed. In linear order they are added with wraparound. The effective address is presented every cycle. It is formed from registered state only, so it changes in the cycle after the clock edge that sampled the controlling inputs.

The processor strobe takes effect only while the active-low select input is low. The controller strobe takes effect whatever the select input is. The address output is a plain control-path signal with no handshake, because a memory port consumes an address in every cycle.

Top module: `bst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe sampled, `addr_out` is all zeros.
- R2: A rising clock edge that samples `adsc_n` low loads `addr_in` into the address register, whatever the value of `sel_n`. After that edge, `addr_out` equals the sampled `addr_in`.
- R3: A rising clock edge that samples `adsp_n` low together with `sel_n` low loads `addr_in`. After that edge, `addr_out` equals the sampled `addr_in`.
- R4: When `adsp_n` is sampled low with `sel_n` high and `adsc_n` high, no load occurs. With `adv_n` high in that cycle, `addr_out` keeps its previous value.
- R5: An edge with no load and `adv_n` low increments the beat count by one, modulo 4 (for the default 2-bit counter).
- R6: An edge with no load and `adv_n` high leaves the beat count and `addr_out` unchanged.
- R7: With `mode_lin` = 0 (interleaved), the two low bits of `addr_out` equal the captured start bits XOR the beat count. A start of 1 gives the sequence 1,0,3,2.
- R8: With `mode_lin` = 1 (linear), the two low bits equal the start bits plus the beat count, modulo 4. A start of 1 gives the sequence 1,2,3,0.
- R9: After the fourth advance, the count wraps to 0 and `addr_out` returns to the captured start address. It does not stop at the last beat.
- R10: `addr_out[ADDR_W-1:2]` stays unchanged on every edge that does not load.
- R11: A load in the middle of a burst captures the new address and clears the count to 0. It takes priority over `adv_n` sampled low on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; gates the processor strobe |
| adsp_n | input | 1 | Active-low processor-side burst start strobe |
| adsc_n | input | 1 | Active-low controller-side burst start strobe |
| adv_n | input | 1 | Active-low beat advance |
| mode_lin | input | 1 | Ordering: 0 interleaved (XOR), 1 linear (add with wrap) |
| addr_in | input | ADDR_W (19) | External address captured on a load |
| addr_out | output | ADDR_W (19) | Effective word address for the current beat |

## Verification
The bound checker examines every cycle for four things:
- the effect of each strobe on the next address, including the case where the processor strobe is blocked by `sel_n`;
- clearing of the counter on a load;
- the single-step increment with wrap of the counter;
- the stability of the upper bits and the held address when neither a load nor an advance occurs.

The XOR and add orderings, the return to the start address after four beats, and a restart in the middle of a burst are shown by the bench scenarios. Those scenarios compare the output with a behavioural model on every clock, and they also compare the low bits with literal expected sequences.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Ordering of beats inside a burst, selected by a static input.
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } bst_order_e;

  // Which strobe caused a load (for readability of the arbiter).
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_PROC = 2'd2
  } bst_src_e;

endpackage

// File: rtl/bst_strobe_arb.sv
module bst_strobe_arb
  import bst_pkg::*;
(
  input  logic     sel_n,
  input  logic     adsp_n,
  input  logic     adsc_n,
  output logic     load,
  output bst_src_e src
);

  // Controller strobe is honoured regardless of select; the processor
  // strobe only counts while the block is selected.
  always_comb begin
    if (!adsc_n) begin
      src = SRC_CTRL;
    end else if (!adsp_n && !sel_n) begin
      src = SRC_PROC;
    end else begin
      src = SRC_NONE;
    end
  end

  assign load = (src != SRC_NONE);

endmodule

// File: rtl/bst_addr_reg.sv
module bst_addr_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Clear wins over advance; the counter wraps naturally at its width.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/bst_seq_map.sv
module bst_seq_map
  import bst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] cnt,
  input  bst_order_e       order,
  output logic [CNT_W-1:0] low
);

  logic [CNT_W-1:0] low_xor;
  logic [CNT_W-1:0] low_add;

  // Interleaved ordering: each bit toggled by the matching count bit.
  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign low_xor[b] = start[b] ^ cnt[b];
  end

  // Linear ordering: modular add, the carry out is dropped.
  assign low_add = start + cnt;

  always_comb begin
    unique case (order)
      ORD_LINEAR:     low = low_add;
      ORD_INTERLEAVE: low = low_xor;
      default:        low = low_xor;
    endcase
  end

endmodule

// File: rtl/bst_addr_gen.sv
module bst_addr_gen
  import bst_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              mode_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic              load;
  bst_src_e          src;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  low;
  bst_order_e        order;

  assign order = mode_lin ? ORD_LINEAR : ORD_INTERLEAVE;

  bst_strobe_arb u_arb (
    .sel_n  (sel_n),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .load   (load),
    .src    (src)
  );

  bst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (addr_in),
    .q     (base_q)
  );

  bst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .adv   (!adv_n),
    .cnt   (cnt_q)
  );

  bst_seq_map #(.CNT_W(CNT_W)) u_map (
    .start (base_q[CNT_W-1:0]),
    .cnt   (cnt_q),
    .order (order),
    .low   (low)
  );

  logic [UP_W-1:0] upper;
  assign upper    = base_q[ADDR_W-1:CNT_W];
  assign addr_out = {upper, low};

endmodule

// File: rtl/bst_addr_gen_chk.sv
module bst_addr_gen_chk #(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              mode_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  cnt_q
);

  logic no_load;
  assign no_load = adsc_n && (adsp_n || sel_n);

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !adsc_n |=> addr_out == $past(addr_in)); // R2

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !sel_n) |=> addr_out == $past(addr_in)); // R3

  AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && sel_n && adsc_n && adv_n) |=>
      (mode_lin != $past(mode_lin)) || $stable(addr_out)); // R4

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !adv_n) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && adv_n) |=> $stable(cnt_q)); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    no_load |=> $stable(addr_out[ADDR_W-1:CNT_W])); // R10

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_load && !adv_n) |=> cnt_q == '0); // R11

endmodule

bind bst_addr_gen bst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .adsp_n   (adsp_n),
  .adsc_n   (adsc_n),
  .adv_n    (adv_n),
  .mode_lin (mode_lin),
  .addr_in  (addr_in),
  .addr_out (addr_out),
  .cnt_q    (cnt_q)
);

// File: tb/test_bst_addr_gen.sv
module test_bst_addr_gen;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1;
  logic          adsp_n = 1'b1;
  logic          adsc_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          mode_lin = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int errors = 0;
  int checks = 0;

  // Behavioural reference state
  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;

  always #10 clk = ~clk;

  bst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) i_bst_addr_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .mode_lin (mode_lin),
    .addr_in  (addr_in),
    .addr_out (addr_out)
  );

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (mode_lin) lo = (int'(m_base[1:0]) + m_cnt) % 4;
    else          lo = int'(m_base[1:0]) ^ m_cnt;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check_addr(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
    end
  endtask

  task automatic check_low(input logic [1:0] exp, input string tag);
    checks++;
    if (addr_out[1:0] !== exp) begin
      errors++;
      $display("FAIL %s: low=%0d expected=%0d", tag, addr_out[1:0], exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(input logic p, input logic c, input logic a, input logic s,
                      input logic [AW-1:0] ad, input string tag);
    adsp_n = p; adsc_n = c; adv_n = a; sel_n = s; addr_in = ad;
    @(posedge clk);
    if (!c || (!p && !s)) begin
      m_base = ad;
      m_cnt  = 0;
    end else if (!a) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check_addr(model_addr(), tag);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check_addr('0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 1, 1, 19'h7FFFF, "R1 after release");
    check_addr('0, "R1 zero after release");

    // R2: controller strobe while deselected
    step(1, 0, 1, 1, 19'h2A5A1, "R2 ctrl load deselected");
    check_addr(19'h2A5A1, "R2 literal");

    // R7: interleaved, start 1 -> 1,0,3,2
    mode_lin = 1'b0;
    step(1, 1, 0, 1, 19'h0, "R7 beat1");
    check_low(2'd0, "R7 seq beat1");
    step(1, 1, 0, 1, 19'h0, "R7 beat2");
    check_low(2'd3, "R7 seq beat2");
    step(1, 1, 0, 1, 19'h0, "R7 beat3");
    check_low(2'd2, "R7 seq beat3");
    // R9: fourth advance wraps to start
    step(1, 1, 0, 1, 19'h0, "R9 wrap");
    check_addr(19'h2A5A1, "R9 back to start");
    check_addr({19'h2A5A1 >> 2, 2'b01}, "R10 upper kept");

    // R6: hold with advance deasserted
    step(1, 1, 1, 1, 19'h11111, "R6 hold");
    check_addr(19'h2A5A1, "R6 literal hold");

    // R3: processor strobe while selected
    step(0, 1, 1, 0, 19'h40005, "R3 proc load");
    check_addr(19'h40005, "R3 literal");

    // R8: linear, start 1 -> 1,2,3,0
    mode_lin = 1'b1;
    step(1, 1, 0, 0, 19'h0, "R8 beat1");
    check_low(2'd2, "R8 seq beat1");
    step(1, 1, 0, 0, 19'h0, "R8 beat2");
    check_low(2'd3, "R8 seq beat2");
    step(1, 1, 0, 0, 19'h0, "R8 beat3");
    check_low(2'd0, "R8 seq beat3");
    check_addr({19'h40005 >> 2, 2'b00}, "R10 upper kept linear");
    step(1, 1, 0, 0, 19'h0, "R9 linear wrap");
    check_addr(19'h40005, "R9 linear back to start");

    // R4: processor strobe while deselected is ignored
    step(1, 1, 0, 1, 19'h0, "R5 advance");
    step(0, 1, 1, 1, 19'h3FFFC, "R4 blocked hold");
    check_addr(19'h40006, "R4 literal no load");
    step(0, 1, 0, 1, 19'h3FFFC, "R4 blocked with advance");
    check_addr(19'h40007, "R5 advance after blocked strobe");

    // R11: restart mid-burst beats advance
    step(1, 0, 0, 1, 19'h12342, "R11 reload");
    check_addr(19'h12342, "R11 literal reload count cleared");
    step(1, 1, 0, 1, 19'h0, "R11 next beat");
    check_low(2'd3, "R11 count restarted");
    step(0, 1, 0, 0, 19'h55553, "R11 proc reload over adv");
    check_addr(19'h55553, "R11 proc literal");

    // Mixed pattern in interleaved mode with both strobes
    mode_lin = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(((i % 7) == 0) ? 1'b0 : 1'b1, ((i % 11) == 5) ? 1'b0 : 1'b1,
           ((i % 3) == 2) ? 1'b1 : 1'b0, ((i % 2) == 0) ? 1'b0 : 1'b1,
           AW'(i * 4099 + 3), "R5 R7 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule